// File: doc/BRIEF.md
# Interrupt Destination Resolver

This block turns one interrupt routing request into a sequence of injection messages addressed to individual processors. A request gives a destination byte, a destination mode (physical or logical), a delivery-mode code, a vector and a trigger mode. The block keeps a small table with one entry per processor. Each entry holds a present flag, a physical identifier and a logical group mask. From the request and the table it forms a bitmask of selected processors. It then emits one message per chosen processor on a valid/ready output.

Two delivery modes are handled. Fixed delivery sends the message to every selected processor in ascending index order. Lowest-priority delivery sends it to exactly one selected processor, chosen by a rotating pointer. Any other delivery code is dropped. While the block works through a bitmask, `busy` is high and new requests are not taken.

Top module: `irq_dest_resolver`

## Requirements
- R1: After reset, `busy` and `inj_valid` are low, every table entry is marked not present and the rotation pointer is 0.
- R2: In physical mode (`req_dest_mode`=0), a destination of all ones selects every present processor.
- R3: In physical mode with any other destination, only the lowest-index present processor whose physical identifier equals the destination is selected.
- R4: In logical mode (`req_dest_mode`=1), a destination of zero selects no processor.
- R5: In logical mode with a nonzero destination, every present processor whose logical mask shares at least one set bit with the destination is selected.
- R6: A request whose selected set is empty produces no message, and `busy` stays low.
- R7: Delivery code 0 (fixed) produces exactly one message per selected processor, with target indices strictly ascending.
- R8: Delivery code 1 (lowest priority) produces exactly one message. Its target is the first selected index found when searching upward from the rotation pointer with wrap-around. The pointer then becomes that index plus one, modulo the processor count.
- R9: Delivery codes 2 to 7 produce no message and leave the rotation pointer unchanged.
- R10: Each message carries the request's vector and trigger mode. While `inj_valid` is high and `inj_ready` is low, the target, vector and trigger stay stable.
- R11: A request is taken when `req_valid` is high and `busy` is low. `busy` rises the cycle after a request that selects at least one processor is taken, and it falls the cycle after the last message's handshake. Requests presented while `busy` is high are ignored.
- R12: A table write (`tbl_wr`) updates the entry at `tbl_idx`. Requests taken in later cycles use the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_wr | input | 1 | Write strobe for the processor table |
| tbl_idx | input | IDX_W | Table entry to write |
| tbl_present | input | 1 | Present flag to store |
| tbl_phys_id | input | DEST_W | Physical identifier to store |
| tbl_log_mask | input | DEST_W | Logical group mask to store |
| req_valid | input | 1 | Request strobe |
| req_dest | input | DEST_W | Destination byte |
| req_dest_mode | input | 1 | 0 physical, 1 logical |
| req_deliv | input | 3 | Delivery code: 0 fixed, 1 lowest priority, others dropped |
| req_vector | input | VEC_W | Interrupt vector |
| req_trig | input | 1 | Trigger mode carried to the messages |
| busy | output | 1 | Walk in progress; requests not taken |
| inj_valid | output | 1 | Message valid |
| inj_ready | input | 1 | Consumer accepts the message |
| inj_target | output | IDX_W | Processor index of the message |
| inj_vector | output | VEC_W | Vector of the message |
| inj_trig | output | 1 | Trigger mode of the message |

## Verification
The properties assume that a request is only taken while `busy` is low. They also assume the consumer may stall `inj_ready` for any number of cycles. They assume nothing about table writes during a walk, because the selected set is captured when the request is taken. The directed stimulus sends each request for one cycle and waits until `busy` has fallen before the next one. The exception is a stray request that is sent on purpose during a stalled walk. Every delivery code the bench uses is either 0, 1 or a code from the dropped range.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;
  localparam int DLV_W = 3;
  localparam logic [DLV_W-1:0] DLV_FIXED  = 3'd0;
  localparam logic [DLV_W-1:0] DLV_LOWEST = 3'd1;
  localparam logic MODE_PHYS = 1'b0;
  localparam logic MODE_LOGIC = 1'b1;
endpackage

// File: rtl/irq_tgt_table.sv
module irq_tgt_table #(
  parameter int N_TGT  = 8,
  parameter int DEST_W = 8,
  localparam int IDX_W = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr,
  input  logic [IDX_W-1:0]              idx,
  input  logic                          present_in,
  input  logic [DEST_W-1:0]             phys_in,
  input  logic [DEST_W-1:0]             lmask_in,
  output logic [N_TGT-1:0]              present,
  output logic [N_TGT-1:0][DEST_W-1:0]  phys,
  output logic [N_TGT-1:0][DEST_W-1:0]  lmask
);
  for (genvar i = 0; i < N_TGT; i++) begin : g_ent
    logic en;
    assign en = wr && (idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        present[i] <= 1'b0;
        phys[i]    <= '0;
        lmask[i]   <= '0;
      end else if (en) begin
        present[i] <= present_in;
        phys[i]    <= phys_in;
        lmask[i]   <= lmask_in;
      end
    end
  end
endmodule

// File: rtl/irq_dest_match.sv
module irq_dest_match #(
  parameter int N_TGT  = 8,
  parameter int DEST_W = 8
) (
  input  logic [N_TGT-1:0]              present,
  input  logic [N_TGT-1:0][DEST_W-1:0]  phys,
  input  logic [N_TGT-1:0][DEST_W-1:0]  lmask,
  input  logic [DEST_W-1:0]             dest,
  input  logic                          dest_mode,
  output logic [N_TGT-1:0]              sel
);
  import irq_dest_pkg::*;

  logic [N_TGT-1:0] phys_hit;
  logic [N_TGT-1:0] log_hit;
  logic [N_TGT-1:0] phys_first;
  logic             bcast;

  assign bcast = (dest == {DEST_W{1'b1}});

  for (genvar i = 0; i < N_TGT; i++) begin : g_cmp
    assign phys_hit[i] = present[i] && (phys[i] == dest);
    assign log_hit[i]  = present[i] && ((lmask[i] & dest) != '0);
  end

  always_comb begin
    logic found;
    found      = 1'b0;
    phys_first = '0;
    for (int i = 0; i < N_TGT; i++) begin
      if (phys_hit[i] && !found) begin
        phys_first[i] = 1'b1;
        found         = 1'b1;
      end
    end
  end

  always_comb begin
    if (dest_mode == MODE_PHYS) begin
      sel = bcast ? present : phys_first;
    end else begin
      sel = (dest == '0) ? '0 : log_hit;
    end
  end
endmodule

// File: rtl/irq_rr_pick.sv
module irq_rr_pick #(
  parameter int N_TGT = 8,
  localparam int IDX_W = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  logic [N_TGT-1:0] cand,
  input  logic [IDX_W-1:0] ptr,
  output logic [N_TGT-1:0] pick_oh,
  output logic [IDX_W-1:0] pick_idx,
  output logic             pick_any
);
  always_comb begin
    int p;
    pick_oh  = '0;
    pick_idx = '0;
    pick_any = 1'b0;
    for (int k = 0; k < N_TGT; k++) begin
      p = int'(ptr) + k;
      if (p >= N_TGT) p = p - N_TGT;
      if (!pick_any && cand[p]) begin
        pick_any    = 1'b1;
        pick_idx    = IDX_W'(p);
        pick_oh[p]  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver #(
  parameter int N_TGT  = 8,
  parameter int DEST_W = 8,
  parameter int VEC_W  = 8,
  localparam int IDX_W = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tbl_wr,
  input  logic [IDX_W-1:0]   tbl_idx,
  input  logic               tbl_present,
  input  logic [DEST_W-1:0]  tbl_phys_id,
  input  logic [DEST_W-1:0]  tbl_log_mask,
  input  logic               req_valid,
  input  logic [DEST_W-1:0]  req_dest,
  input  logic               req_dest_mode,
  input  logic [2:0]         req_deliv,
  input  logic [VEC_W-1:0]   req_vector,
  input  logic               req_trig,
  output logic               busy,
  output logic               inj_valid,
  input  logic               inj_ready,
  output logic [IDX_W-1:0]   inj_target,
  output logic [VEC_W-1:0]   inj_vector,
  output logic               inj_trig
);
  import irq_dest_pkg::*;

  logic [N_TGT-1:0]             t_present;
  logic [N_TGT-1:0][DEST_W-1:0] t_phys;
  logic [N_TGT-1:0][DEST_W-1:0] t_lmask;
  logic [N_TGT-1:0]             sel;
  logic [N_TGT-1:0]             pick_oh;
  logic [IDX_W-1:0]             pick_idx;
  logic                         pick_any;

  logic [N_TGT-1:0] pend_q, pend_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             ptr_en;
  logic [VEC_W-1:0] vec_q;
  logic             trig_q;
  logic             accept;
  logic             is_fixed, is_lowest;
  logic [N_TGT-1:0] cur_oh;
  logic [IDX_W-1:0] cur_idx;
  logic             hs;

  irq_tgt_table #(.N_TGT(N_TGT), .DEST_W(DEST_W)) u_table (
    .clk(clk), .rst_n(rst_n), .wr(tbl_wr), .idx(tbl_idx),
    .present_in(tbl_present), .phys_in(tbl_phys_id), .lmask_in(tbl_log_mask),
    .present(t_present), .phys(t_phys), .lmask(t_lmask)
  );

  irq_dest_match #(.N_TGT(N_TGT), .DEST_W(DEST_W)) u_match (
    .present(t_present), .phys(t_phys), .lmask(t_lmask),
    .dest(req_dest), .dest_mode(req_dest_mode), .sel(sel)
  );

  irq_rr_pick #(.N_TGT(N_TGT)) u_rr (
    .cand(sel), .ptr(ptr_q),
    .pick_oh(pick_oh), .pick_idx(pick_idx), .pick_any(pick_any)
  );

  assign busy      = |pend_q;
  assign accept    = req_valid && !busy;
  assign is_fixed  = (req_deliv == DLV_FIXED);
  assign is_lowest = (req_deliv == DLV_LOWEST);
  assign hs        = busy && inj_ready;

  // lowest pending index is the next message
  always_comb begin
    logic found;
    found   = 1'b0;
    cur_oh  = '0;
    cur_idx = '0;
    for (int i = 0; i < N_TGT; i++) begin
      if (pend_q[i] && !found) begin
        found     = 1'b1;
        cur_oh[i] = 1'b1;
        cur_idx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    pend_d = pend_q;
    ptr_d  = ptr_q;
    ptr_en = 1'b0;
    if (accept) begin
      if (is_fixed) begin
        pend_d = sel;
      end else if (is_lowest) begin
        pend_d = pick_oh;
        if (pick_any) begin
          ptr_en = 1'b1;
          ptr_d  = (pick_idx == IDX_W'(N_TGT - 1)) ? '0 : pick_idx + 1'b1;
        end
      end else begin
        pend_d = '0;
      end
    end else if (hs) begin
      pend_d = pend_q & ~cur_oh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      trig_q <= 1'b0;
    end else if (accept) begin
      vec_q  <= req_vector;
      trig_q <= req_trig;
    end
  end

  assign inj_valid  = busy;
  assign inj_target = cur_idx;
  assign inj_vector = vec_q;
  assign inj_trig   = trig_q;
endmodule

// File: rtl/irq_dest_resolver_chk.sv
module irq_dest_resolver_chk #(
  parameter int N_TGT  = 8,
  parameter int DEST_W = 8,
  parameter int VEC_W  = 8,
  localparam int IDX_W = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [DEST_W-1:0]  req_dest,
  input logic               req_dest_mode,
  input logic [2:0]         req_deliv,
  input logic               busy,
  input logic               inj_valid,
  input logic               inj_ready,
  input logic [IDX_W-1:0]   inj_target,
  input logic [VEC_W-1:0]   inj_vector,
  input logic               inj_trig
);
  AST_LOGIC_ZERO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy && req_dest_mode && (req_dest == '0) |=> !busy); // R4

  AST_FIXED_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid && inj_ready |=> !inj_valid || (inj_target > $past(inj_target))); // R7

  AST_DROP_OTHER_MODES: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy && (req_deliv > 3'd1) |=> !busy); // R9

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid && !inj_ready |=> inj_valid && $stable(inj_target)
      && $stable(inj_vector) && $stable(inj_trig)); // R10

  AST_BUSY_NEEDS_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(inj_valid && inj_ready) |=> busy); // R11

  AST_WALK_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy || ($stable(inj_vector) && $stable(inj_trig))); // R11
endmodule

bind irq_dest_resolver irq_dest_resolver_chk #(
  .N_TGT(N_TGT), .DEST_W(DEST_W), .VEC_W(VEC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dest(req_dest),
  .req_dest_mode(req_dest_mode), .req_deliv(req_deliv), .busy(busy),
  .inj_valid(inj_valid), .inj_ready(inj_ready), .inj_target(inj_target),
  .inj_vector(inj_vector), .inj_trig(inj_trig)
);

// File: tb/irq_dest_resolver_test.sv
module irq_dest_resolver_test;
  localparam int N = 8;
  localparam int DW = 8;
  localparam int VW = 8;
  localparam int IW = 3;

  logic clk, rst_n;
  logic tbl_wr, tbl_present;
  logic [IW-1:0] tbl_idx;
  logic [DW-1:0] tbl_phys_id, tbl_log_mask;
  logic req_valid, req_dest_mode, req_trig;
  logic [DW-1:0] req_dest;
  logic [2:0] req_deliv;
  logic [VW-1:0] req_vector;
  logic busy, inj_valid, inj_ready, inj_trig;
  logic [IW-1:0] inj_target;
  logic [VW-1:0] inj_vector;

  int checks = 0;
  int errors = 0;

  bit          m_pres [N];
  logic [DW-1:0] m_phys [N];
  logic [DW-1:0] m_lmask [N];
  int          m_ptr = 0;

  irq_dest_resolver #(.N_TGT(N), .DEST_W(DW), .VEC_W(VW)) uut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: act=running exp=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic wr_tbl(input int i, input bit pres, input int ph, input int lm);
    @(negedge clk);
    tbl_wr = 1'b1; tbl_idx = IW'(i); tbl_present = pres;
    tbl_phys_id = DW'(ph); tbl_log_mask = DW'(lm);
    @(negedge clk);
    tbl_wr = 1'b0;
    m_pres[i] = pres; m_phys[i] = DW'(ph); m_lmask[i] = DW'(lm);
  endtask

  function automatic int model_sel(input int dest, input bit mode);
    int s = 0;
    if (!mode) begin
      if (dest == 255) begin
        for (int i = 0; i < N; i++) if (m_pres[i]) s |= (1 << i);
      end else begin
        for (int i = 0; i < N; i++)
          if (m_pres[i] && m_phys[i] == DW'(dest)) begin s = (1 << i); break; end
      end
    end else if (dest != 0) begin
      for (int i = 0; i < N; i++)
        if (m_pres[i] && ((m_lmask[i] & DW'(dest)) != 0)) s |= (1 << i);
    end
    return s;
  endfunction

  // sends one request, drains with ready high, compares against the model
  task automatic run_req(input int dest, input bit mode, input int deliv,
                         input int vec, input bit trig, input string tag);
    int s, exp, got, cnt, last;
    bit asc;
    s = model_sel(dest, mode);
    exp = 0;
    if (deliv == 0) exp = s;
    else if (deliv == 1 && s != 0) begin
      for (int k = 0; k < N; k++) begin
        int p = (m_ptr + k) % N;
        if (s[p]) begin exp = (1 << p); m_ptr = (p + 1) % N; break; end
      end
    end
    @(negedge clk);
    inj_ready = 1'b1;
    req_valid = 1'b1; req_dest = DW'(dest); req_dest_mode = mode;
    req_deliv = 3'(deliv); req_vector = VW'(vec); req_trig = trig;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == (exp != 0), tag, "busy after accept", int'(busy), int'(exp != 0));
    got = 0; cnt = 0; last = -1; asc = 1'b1;
    for (int g = 0; g < N + 2 && inj_valid; g++) begin
      if (int'(inj_target) <= last) asc = 1'b0;
      last = int'(inj_target);
      got |= (1 << inj_target);
      cnt++;
      if (inj_vector != VW'(vec) || inj_trig != trig) begin
        chk(1'b0, "R10", "message vector", int'(inj_vector), vec);
      end
      @(negedge clk);
    end
    chk(got == exp, tag, "target set", got, exp);
    chk(cnt == $countones(exp), tag, "message count", cnt, $countones(exp));
    chk(asc, "R7", "ascending order", int'(asc), 1);
    chk(!busy, "R11", "busy low after walk", int'(busy), 0);
  endtask

  task automatic t_reset;
    chk(!busy, "R1", "busy at reset", int'(busy), 0);
    chk(!inj_valid, "R1", "inj_valid at reset", int'(inj_valid), 0);
    run_req(255, 1'b0, 0, 8'h20, 1'b0, "R1");
  endtask

  task automatic t_load;
    wr_tbl(0, 1, 3, 8'h01);
    wr_tbl(1, 1, 7, 8'h02);
    wr_tbl(2, 1, 3, 8'h04);
    wr_tbl(3, 1, 9, 8'h01);
    wr_tbl(4, 1, 1, 8'h10);
    wr_tbl(5, 0, 4, 8'h01);
    wr_tbl(6, 1, 4, 8'h20);
    wr_tbl(7, 1, 2, 8'h80);
  endtask

  task automatic t_physical;
    run_req(255, 1'b0, 0, 8'h31, 1'b1, "R2");
    run_req(3, 1'b0, 0, 8'h32, 1'b0, "R3");
    run_req(4, 1'b0, 0, 8'h33, 1'b1, "R3");
    run_req(8'h55, 1'b0, 0, 8'h34, 1'b0, "R6");
  endtask

  task automatic t_logical;
    run_req(0, 1'b1, 0, 8'h35, 1'b0, "R4");
    run_req(8'h05, 1'b1, 0, 8'h36, 1'b1, "R5");
    run_req(8'hB0, 1'b1, 0, 8'h37, 1'b0, "R5");
  endtask

  task automatic t_lowest;
    run_req(8'h05, 1'b1, 1, 8'h40, 1'b0, "R8");
    run_req(8'h05, 1'b1, 1, 8'h41, 1'b1, "R8");
    run_req(255, 1'b0, 2, 8'h42, 1'b0, "R9");
    run_req(8'h05, 1'b1, 7, 8'h43, 1'b0, "R9");
    run_req(8'h05, 1'b1, 1, 8'h44, 1'b0, "R8");
    run_req(8'h05, 1'b1, 1, 8'h45, 1'b1, "R8");
  endtask

  task automatic t_stall;
    int seq [3];
    int n;
    @(negedge clk);
    inj_ready = 1'b0;
    req_valid = 1'b1; req_dest = 8'h05; req_dest_mode = 1'b1;
    req_deliv = 3'd0; req_vector = 8'h61; req_trig = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(inj_valid && inj_target == 0, "R10", "first target", int'(inj_target), 0);
    @(negedge clk);
    req_valid = 1'b1; req_dest = 8'hFF; req_dest_mode = 1'b0;
    req_deliv = 3'd0; req_vector = 8'h99; req_trig = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(inj_valid && inj_target == 0, "R10", "target held in stall", int'(inj_target), 0);
    chk(inj_vector == 8'h61 && inj_trig, "R11", "vector kept while busy", int'(inj_vector), 8'h61);
    inj_ready = 1'b1;
    n = 0;
    for (int g = 0; g < 6 && inj_valid; g++) begin
      if (n < 3) seq[n] = int'(inj_target);
      n++;
      @(negedge clk);
    end
    chk(n == 3, "R11", "messages after stall", n, 3);
    chk(seq[0] == 0 && seq[1] == 2 && seq[2] == 3, "R7", "stall walk order", seq[2], 3);
    @(negedge clk);
    chk(!busy && !inj_valid, "R11", "stray request ignored", int'(busy), 0);
  endtask

  task automatic t_rewrite;
    wr_tbl(3, 0, 9, 8'h01);
    run_req(8'h05, 1'b1, 0, 8'h70, 1'b0, "R12");
    wr_tbl(6, 1, 3, 8'h20);
    run_req(3, 1'b0, 0, 8'h71, 1'b0, "R12");
    wr_tbl(0, 0, 3, 8'h01);
    run_req(3, 1'b0, 0, 8'h72, 1'b1, "R12");
  endtask

  initial begin
    rst_n = 1'b0;
    tbl_wr = 1'b0; tbl_idx = '0; tbl_present = 1'b0;
    tbl_phys_id = '0; tbl_log_mask = '0;
    req_valid = 1'b0; req_dest = '0; req_dest_mode = 1'b0;
    req_deliv = '0; req_vector = '0; req_trig = 1'b0; inj_ready = 1'b1;
    for (int i = 0; i < N; i++) begin m_pres[i] = 0; m_phys[i] = '0; m_lmask[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_load;
    t_physical;
    t_logical;
    t_lowest;
    t_stall;
    t_rewrite;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule